// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Control

This block keeps the exception part of a floating-point status/control register and decides when a floating-point instruction must stop and report an exception to the CPU. It holds three five-bit fields. The enable field is written only by software. The sticky flag field collects every condition detected since software last cleared it. The cause field shows only the conditions of the most recent exception-capable instruction.

Each cycle the datapath may present one instruction on the valid strobe. With it come the raw result-status bits, a class code naming the instruction, and hints that a source operand is a quiet NaN or an infinity. A capability mask derived from the class filters the raw status, so an instruction can report only the conditions it is able to produce. An optional mode traps on quiet-NaN or infinite source operands through the invalid enable. If a reported condition meets its enable, the block raises halt to the floating-point pipeline in the same cycle and issues a one-cycle exception request to the CPU one cycle later.

Top module: `fpexc_ctrl`

## Requirements
- R1: After reset, enable_o, flag_o and cause_o are all zero, and exc_req_o and halt_o are low.
- R2: Within each field the bits are ordered V (invalid) at bit 4, Z (divide-by-zero) at bit 3, O (overflow) at bit 2, U (underflow) at bit 1 and I (inexact) at bit 0. With wr_en_i high, the next cycle shows wr_data_i[4:0] in enable_o, wr_data_i[9:5] in flag_o and wr_data_i[14:10] in cause_o. Only this write changes enable_o.
- R3: With ins_valid_i high and no write, cause_o takes the new cause in the next cycle, replacing the old value completely. The new cause is the filtered status, plus V when a QIS trap is taken. With neither strobe high, cause_o keeps its value.
- R4: With ins_valid_i high and no write, flag_o becomes the OR of its old value and the new cause. Without a write, no flag bit ever clears.
- R5: When wr_en_i and ins_valid_i are high in the same cycle, the written value sets all three fields and the instruction's conditions are discarded.
- R6: halt_o is high in the same cycle as ins_valid_i when the new cause ANDed with enable_o is non-zero. It is never high without ins_valid_i.
- R7: exc_req_o is high for exactly the cycle after each cycle in which halt_o is high, and at no other time.
- R8: A condition whose enable bit is 0 still sets its cause and flag bits, but raises neither halt_o nor exc_req_o. With enable_o zero, no trap occurs.
- R9: A QIS trap is taken when an exception-capable instruction is valid, qis_i is 1, enable V is 1, and op_qnan_i or op_inf_i is 1. It then traps and sets V in cause and flag. If qis_i or enable V is 0, the operand hints have no effect.
- R10: The class codes are 0 add, 1 sub, 2 mul, 3 div, 4 mac, 5 cmp-eq, 6 cmp-gt, 7 int-to-float, 8 truncate, 9 double-to-single, 10 single-to-double and 11 sqrt. Codes 12 to 15 cannot raise exceptions, and their mask is zero. Every code from 0 to 11 allows V. Z is allowed only for div. O and U are allowed for add, sub, mul, div, mac and double-to-single. I is allowed for those same classes and also for int-to-float and sqrt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | An instruction completes this cycle |
| ins_class_i | input | 4 | Instruction class code |
| status_i | input | 5 | Raw result-status bits from the datapath |
| op_qnan_i | input | 1 | A source operand is a quiet NaN |
| op_inf_i | input | 1 | A source operand is an infinity |
| qis_i | input | 1 | Trap on quiet-NaN or infinite sources |
| wr_en_i | input | 1 | Software register write strobe |
| wr_data_i | input | 15 | Write data: cause, flag and enable |
| enable_o | output | 5 | Enable field |
| flag_o | output | 5 | Sticky flag field |
| cause_o | output | 5 | Cause field |
| halt_o | output | 1 | Stop the FP pipeline this cycle |
| exc_req_o | output | 1 | One-cycle exception request to the CPU |

## Verification
The assertions assume that every input is known and stable around each rising edge, and that all inputs are held low during reset. They also assume that the status bits may take any pattern, because the class mask, not the datapath, is trusted to filter them. The stimulus changes inputs only on falling edges and returns the strobes to zero after each operation. It reaches the write-versus-instruction collision and all sixteen class codes through the normal ports only.

// File: rtl/fpexc_pkg.sv
package fpexc_pkg;
  localparam int unsigned FLD_W = 5;
  localparam int unsigned CLS_W = 4;
  localparam int unsigned REG_W = 3 * FLD_W;

  localparam int unsigned B_I = 0;
  localparam int unsigned B_U = 1;
  localparam int unsigned B_O = 2;
  localparam int unsigned B_Z = 3;
  localparam int unsigned B_V = 4;

  typedef logic [FLD_W-1:0] exc_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD  = 4'd0,
    CLS_SUB  = 4'd1,
    CLS_MUL  = 4'd2,
    CLS_DIV  = 4'd3,
    CLS_MAC  = 4'd4,
    CLS_CEQ  = 4'd5,
    CLS_CGT  = 4'd6,
    CLS_I2F  = 4'd7,
    CLS_TRC  = 4'd8,
    CLS_D2S  = 4'd9,
    CLS_S2D  = 4'd10,
    CLS_SQRT = 4'd11
  } cls_e;

  typedef struct packed {
    exc_t cause;
    exc_t flag;
    exc_t enable;
  } fpscr_t;
endpackage

// File: rtl/fpexc_capmask.sv
module fpexc_capmask
  import fpexc_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output exc_t             mask_o
);
  localparam exc_t M_V    = exc_t'(1) << B_V;
  localparam exc_t M_Z    = exc_t'(1) << B_Z;
  localparam exc_t M_OU   = (exc_t'(1) << B_O) | (exc_t'(1) << B_U);
  localparam exc_t M_I    = exc_t'(1) << B_I;
  localparam exc_t M_ARITH = M_V | M_OU | M_I;

  always_comb begin
    unique case (cls_i)
      CLS_ADD, CLS_SUB, CLS_MUL, CLS_MAC, CLS_D2S: mask_o = M_ARITH;
      CLS_DIV:                                     mask_o = M_ARITH | M_Z;
      CLS_I2F, CLS_SQRT:                           mask_o = M_V | M_I;
      CLS_CEQ, CLS_CGT, CLS_TRC, CLS_S2D:          mask_o = M_V;
      default:                                     mask_o = '0;
    endcase
  end
endmodule

// File: rtl/fpexc_cause.sv
module fpexc_cause
  import fpexc_pkg::*;
(
  input  logic valid_i,
  input  exc_t status_i,
  input  exc_t cap_i,
  input  exc_t enable_i,
  input  logic qis_i,
  input  logic qnan_i,
  input  logic inf_i,
  output exc_t cause_o,
  output logic trap_o
);
  logic qis_hit;
  exc_t qis_vec;

  // special-operand trap only for instructions that may report invalid
  assign qis_hit = valid_i & qis_i & enable_i[B_V] & cap_i[B_V] & (qnan_i | inf_i);
  assign qis_vec = qis_hit ? (exc_t'(1) << B_V) : '0;
  assign cause_o = valid_i ? ((status_i & cap_i) | qis_vec) : '0;
  assign trap_o  = valid_i & (|(cause_o & enable_i));
endmodule

// File: rtl/fpexc_regs.sv
module fpexc_regs
  import fpexc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               upd_i,
  input  exc_t               cause_new_i,
  input  logic               trap_i,
  output fpscr_t             csr_o,
  output logic               req_o
);
  fpscr_t csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= trap_i;
      if (wr_en_i) begin
        csr_q <= fpscr_t'(wr_data_i);
      end else if (upd_i) begin
        csr_q.cause <= cause_new_i;
        csr_q.flag  <= csr_q.flag | cause_new_i;
      end
    end
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/fpexc_ctrl.sv
module fpexc_ctrl
  import fpexc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_valid_i,
  input  logic [CLS_W-1:0]     ins_class_i,
  input  logic [FLD_W-1:0]     status_i,
  input  logic                 op_qnan_i,
  input  logic                 op_inf_i,
  input  logic                 qis_i,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic [FLD_W-1:0]     enable_o,
  output logic [FLD_W-1:0]     flag_o,
  output logic [FLD_W-1:0]     cause_o,
  output logic                 halt_o,
  output logic                 exc_req_o
);
  exc_t   cap;
  exc_t   cause_new;
  logic   trap;
  fpscr_t csr;

  fpexc_capmask u_cap (
    .cls_i  (ins_class_i),
    .mask_o (cap)
  );

  fpexc_cause u_cause (
    .valid_i  (ins_valid_i),
    .status_i (status_i),
    .cap_i    (cap),
    .enable_i (csr.enable),
    .qis_i    (qis_i),
    .qnan_i   (op_qnan_i),
    .inf_i    (op_inf_i),
    .cause_o  (cause_new),
    .trap_o   (trap)
  );

  fpexc_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .upd_i       (ins_valid_i),
    .cause_new_i (cause_new),
    .trap_i      (trap),
    .csr_o       (csr),
    .req_o       (exc_req_o)
  );

  assign enable_o = csr.enable;
  assign flag_o   = csr.flag;
  assign cause_o  = csr.cause;
  assign halt_o   = trap;
endmodule

// File: rtl/fpexc_ctrl_chk.sv
module fpexc_ctrl_chk
  import fpexc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ins_valid_i,
  input logic [CLS_W-1:0] ins_class_i,
  input logic             op_qnan_i,
  input logic             op_inf_i,
  input logic             qis_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [FLD_W-1:0] enable_o,
  input logic [FLD_W-1:0] flag_o,
  input logic [FLD_W-1:0] cause_o,
  input logic             halt_o,
  input logic             exc_req_o
);
  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ({cause_o, flag_o, enable_o} == $past(wr_data_i))); // R5
  AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(enable_o)); // R2
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !ins_valid_i) |=> $stable(cause_o)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R4
  AST_HALT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> ins_valid_i); // R6
  AST_REQ_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> exc_req_o); // R7
  AST_REQ_ONLY_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |=> !exc_req_o); // R7
  AST_NO_ENABLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o == '0) |-> !halt_o); // R8
  AST_QIS_SETS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !wr_en_i && qis_i && enable_o[B_V] && (op_qnan_i || op_inf_i)
     && (ins_class_i < CLS_W'(12))) |=> (cause_o[B_V] && flag_o[B_V])); // R9
  AST_NONCAP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !wr_en_i && (ins_class_i >= CLS_W'(12))) |=> (cause_o == '0)); // R10
endmodule

bind fpexc_ctrl fpexc_ctrl_chk u_chk (.*);

// File: tb/fpexc_ctrl_test.sv
module fpexc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [3:0]  ins_class = '0;
  logic [4:0]  status = '0;
  logic        op_qnan = 1'b0;
  logic        op_inf = 1'b0;
  logic        qis = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_data = '0;
  logic [4:0]  enable, flag, cause;
  logic        halt, exc_req;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpexc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_class_i(ins_class),
    .status_i(status), .op_qnan_i(op_qnan), .op_inf_i(op_inf), .qis_i(qis),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .enable_o(enable), .flag_o(flag),
    .cause_o(cause), .halt_o(halt), .exc_req_o(exc_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // capability mask per class, from R10 (V=4 Z=3 O=2 U=1 I=0)
  function automatic logic [4:0] exp_mask(int c);
    case (c)
      0, 1, 2, 4, 9: return 5'b10111;
      3:             return 5'b11111;
      7, 11:         return 5'b10001;
      5, 6, 8, 10:   return 5'b10000;
      default:       return 5'b00000;
    endcase
  endfunction

  task automatic sw_write(logic [4:0] c, logic [4:0] f, logic [4:0] e);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {c, f, e};
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // drives one instruction; returns halt seen in the same cycle
  task automatic issue(int c, logic [4:0] st, logic qn, logic inf, logic q, output logic h);
    @(negedge clk);
    ins_valid = 1'b1; ins_class = 4'(c); status = st;
    op_qnan = qn; op_inf = inf; qis = q;
    #1 h = halt;
    @(negedge clk);
    ins_valid = 1'b0; ins_class = '0; status = '0;
    op_qnan = 1'b0; op_inf = 1'b0; qis = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 enable", enable, 0);
    chk("R1 flag", flag, 0);
    chk("R1 cause", cause, 0);
    chk("R1 halt", halt, 0);
    chk("R1 exc_req", exc_req, 0);
  endtask

  task automatic t_write();
    sw_write(5'b11111, 5'b01010, 5'b10101);
    chk("R2 enable", enable, 5'b10101);
    chk("R2 flag", flag, 5'b01010);
    chk("R2 cause", cause, 5'b11111);
    sw_write('0, '0, '0);
    chk("R2 clear", {cause, flag, enable}, 0);
  endtask

  task automatic t_cause_flag();
    logic h;
    issue(0, 5'b00110, 0, 0, 0, h);
    chk("R3 cause add", cause, 5'b00110);
    chk("R4 flag add", flag, 5'b00110);
    issue(2, 5'b00001, 0, 0, 0, h);
    chk("R3 cause overwritten", cause, 5'b00001);
    chk("R4 flag accumulates", flag, 5'b00111);
    @(negedge clk);
    chk("R3 cause holds idle", cause, 5'b00001);
    chk("R4 flag holds idle", flag, 5'b00111);
    chk("R8 no trap with enable zero", h, 0);
    sw_write('0, '0, '0);
  endtask

  task automatic t_trap();
    logic h;
    sw_write('0, '0, 5'b00100);
    issue(0, 5'b00100, 0, 0, 0, h);
    chk("R6 halt same cycle", h, 1);
    chk("R7 exc_req after halt", exc_req, 1);
    @(negedge clk);
    chk("R7 exc_req one cycle", exc_req, 0);
    issue(0, 5'b00011, 0, 0, 0, h);
    chk("R8 disabled halt", h, 0);
    chk("R8 disabled exc_req", exc_req, 0);
    chk("R8 flag still set", flag, 5'b00111);
    sw_write('0, '0, 5'b01000);
    issue(3, 5'b01000, 0, 0, 0, h);
    chk("R6 div-by-zero halt", h, 1);
    chk("R7 div-by-zero exc_req", exc_req, 1);
    sw_write('0, '0, '0);
  endtask

  task automatic t_qis();
    logic h;
    sw_write('0, '0, 5'b10000);
    issue(0, 5'b00000, 1, 0, 1, h);
    chk("R9 qnan trap halt", h, 1);
    chk("R9 qnan cause V", cause, 5'b10000);
    chk("R9 qnan flag V", flag, 5'b10000);
    chk("R9 qnan exc_req", exc_req, 1);
    sw_write('0, '0, 5'b10000);
    issue(2, 5'b00000, 0, 1, 0, h);
    chk("R9 qis off halt", h, 0);
    chk("R9 qis off cause", cause, 0);
    sw_write('0, '0, 5'b00000);
    issue(2, 5'b00000, 0, 1, 1, h);
    chk("R9 enable V off halt", h, 0);
    chk("R9 enable V off flag", flag, 0);
    sw_write('0, '0, 5'b10000);
    issue(14, 5'b00000, 1, 1, 1, h);
    chk("R10 qis ignored non-capable", h, 0);
    chk("R10 cause non-capable", cause, 0);
    sw_write('0, '0, '0);
  endtask

  task automatic t_priority();
    sw_write('0, 5'b00001, 5'b00100);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {5'b00010, 5'b01000, 5'b00000};
    ins_valid = 1'b1; ins_class = 4'd0; status = 5'b00111;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ins_valid = 1'b0; status = '0;
    chk("R5 enable from write", enable, 5'b00000);
    chk("R5 flag from write", flag, 5'b01000);
    chk("R5 cause from write", cause, 5'b00010);
    sw_write('0, '0, '0);
  endtask

  task automatic t_masks();
    logic h;
    for (int c = 0; c < 16; c++) begin
      sw_write('0, '0, '0);
      issue(c, 5'b11111, 0, 0, 0, h);
      chk($sformatf("R10 mask class %0d", c), cause, exp_mask(c));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_cause_flag();
    t_trap();
    t_qis();
    t_priority();
    t_masks();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule